// File: doc/BRIEF.md
# Password Verifier with Tamper Lockout

This block checks a 64-bit password that arrives as eight bytes after a protected command byte. The host side delivers already-framed bytes together with start and stop events. The block answers each byte with an acknowledge or a no-acknowledge one clock later. Five stored passwords are held in registers that all reset to zero. The command byte selects which of them a password entry is compared against.

Every completed password entry starts a busy window of fixed length, whether the password matched or not, so the result cannot be read from timing. The result is revealed only by a poll command sent once the window has closed. A poll that succeeds after a normal protected command raises an access-granted level, which stays up until the next stop event. A poll that succeeds after the reset-device command clears the tamper state instead.

Each failed entry advances a tamper counter. The eighth failure sets a sticky tamper bit, and that bit locks out all password commands except reset-device. The tamper bit also appears as the most significant bit of a 32-bit identification word.

Top module: `pwgate_top`

## Requirements
- R1: After reset, grant, locked, tamper_bit and ack_vld are 0, devid equals {1'b0, ID_CODE}, and every stored password is all zeros.
- R2: In command position, codes 80h, 90h, 88h and 98h (memory-read, memory-write, OTP-read and OTP-write passwords) and E8h (reset password) are acknowledged when not busy and not locked. Each of the eight password bytes that follow is acknowledged. The first byte is compared with bits 63:56 of the selected password.
- R3: After the eighth password byte, a busy window of BUSY_CYC cycles runs whether or not the password matched. Every command byte received during that window is answered with no-acknowledge and the block goes to standby.
- R4: The poll code F0h, received after the busy window, is acknowledged only if the last completed entry matched, and it consumes that result. For a command other than E8h, an acknowledged poll raises grant. Any other poll is answered with no-acknowledge.
- R5: Each mismatched entry advances a tamper counter. The TAMPER_MAX-th mismatch (8 by default) sets tamper_bit, and correct entries in between do not reset the count.
- R6: While locked, the codes 80h, 90h, 88h and 98h are answered with no-acknowledge and ignored. E8h, C8h and D8h are still acknowledged.
- R7: An acknowledged poll after a matched E8h entry clears tamper_bit, locked and the counter. grant stays low.
- R8: devid is {tamper_bit, ID_CODE}, and locked follows tamper_bit.
- R9: Any command code not listed in R2, R4 or R6 is answered with no-acknowledge. The block then ignores further bytes until the next start event.
- R10: A start or stop event before the eighth password byte aborts the entry. No busy window starts and no tamper count is taken.
- R11: A stop event clears grant.
- R12: ack_vld pulses exactly in the cycle after an answered byte_vld, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe marking a received byte |
| byte_in | input | 8 | Received byte |
| start_evt | input | 1 | Start condition seen on the bus |
| stop_evt | input | 1 | Stop condition seen on the bus |
| ack_vld | output | 1 | Response for the previous byte is valid |
| ack_out | output | 1 | 1 = acknowledge, 0 = no-acknowledge |
| grant | output | 1 | Protected access granted |
| locked | output | 1 | Password commands locked out |
| tamper_bit | output | 1 | Sticky tamper indication |
| devid | output | 32 | Identification word with tamper in bit 31 |

## Verification
Every protected command code is tried with the all-zero password, which must pass. Entries with a single wrong byte, placed at each of the eight byte positions in turn, must fail. This separates a comparison that covers every byte from one that skips some. Polls sent during the busy window, and immediately after it, separate timing from the match result. A run of seven failures, a correct entry, and then an eighth failure shows that correct entries do not reset the count. Aborted entries followed by an immediately accepted command show that an abort starts no busy window.

// File: rtl/pwg_pkg.sv
package pwg_pkg;

  localparam logic [7:0] CMD_MRD  = 8'h80;
  localparam logic [7:0] CMD_MWR  = 8'h90;
  localparam logic [7:0] CMD_ORD  = 8'h88;
  localparam logic [7:0] CMD_OWR  = 8'h98;
  localparam logic [7:0] CMD_RST  = 8'hE8;
  localparam logic [7:0] CMD_POLL = 8'hF0;
  localparam logic [7:0] CMD_NRD  = 8'hC8;
  localparam logic [7:0] CMD_NWR  = 8'hD8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_PW, ST_DATA, ST_SKIP
  } pwg_state_e;

  typedef enum logic [2:0] {
    PW_MRD, PW_MWR, PW_ORD, PW_OWR, PW_RST
  } pw_sel_e;

  typedef struct packed {
    logic    is_pw;
    logic    is_rst;
    logic    is_poll;
    logic    is_nopw;
    pw_sel_e sel;
  } cmd_info_t;

endpackage

// File: rtl/pwg_cmd_decode.sv
module pwg_cmd_decode
  import pwg_pkg::*;
(
  input  logic [7:0] code,
  output cmd_info_t  info
);
  always_comb begin
    info = '{is_pw: 1'b0, is_rst: 1'b0, is_poll: 1'b0, is_nopw: 1'b0, sel: PW_MRD};
    case (code)
      CMD_MRD:  begin info.is_pw = 1'b1; info.sel = PW_MRD; end
      CMD_MWR:  begin info.is_pw = 1'b1; info.sel = PW_MWR; end
      CMD_ORD:  begin info.is_pw = 1'b1; info.sel = PW_ORD; end
      CMD_OWR:  begin info.is_pw = 1'b1; info.sel = PW_OWR; end
      CMD_RST:  begin info.is_pw = 1'b1; info.is_rst = 1'b1; info.sel = PW_RST; end
      CMD_POLL: info.is_poll = 1'b1;
      CMD_NRD, CMD_NWR: info.is_nopw = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/pwg_pw_store.sv
module pwg_pw_store
  import pwg_pkg::*;
#(
  parameter int PW_BYTES = 8,
  parameter int NUM_PW   = 5,
  localparam int PW_BITS = PW_BYTES * 8,
  localparam int IDXW    = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  pw_sel_e         sel,
  input  logic [IDXW-1:0] idx,
  output logic [7:0]      byte_o
);
  logic [PW_BITS-1:0] pw_q [NUM_PW];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PW; i++) pw_q[i] <= '0;
    end
  end

  // first received byte maps to the most significant byte
  always_comb begin
    byte_o = 8'h00;
    for (int i = 0; i < NUM_PW; i++) begin
      if (int'(sel) == i)
        byte_o = pw_q[i][(PW_BYTES - 1 - int'(idx)) * 8 +: 8];
    end
  end
endmodule

// File: rtl/pwg_busy_timer.sv
module pwg_busy_timer #(
  parameter int BUSY_CYC = 16,
  localparam int CW = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= CW'(BUSY_CYC);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/pwg_tamper.sv
module pwg_tamper #(
  parameter int TAMPER_MAX = 8,
  localparam int CW = (TAMPER_MAX > 1) ? $clog2(TAMPER_MAX) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic miss,
  input  logic clr,
  output logic tamper
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      tamper <= 1'b0;
    end else if (miss) begin
      if (cnt_q == CW'(TAMPER_MAX - 1)) begin
        cnt_q  <= '0;
        tamper <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwgate_top.sv
module pwgate_top
  import pwg_pkg::*;
#(
  parameter int          PW_BYTES   = 8,
  parameter int          BUSY_CYC   = 20,
  parameter int          TAMPER_MAX = 8,
  parameter logic [30:0] ID_CODE    = 31'h0A5C_3E1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  input  logic        start_evt,
  input  logic        stop_evt,
  output logic        ack_vld,
  output logic        ack_out,
  output logic        grant,
  output logic        locked,
  output logic        tamper_bit,
  output logic [31:0] devid
);
  localparam int IDXW = (PW_BYTES > 1) ? $clog2(PW_BYTES) : 1;
  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(PW_BYTES - 1);

  pwg_state_e      st_q;
  pw_sel_e         sel_q;
  logic [IDXW-1:0] idx_q;
  logic            mis_q, pend_ok_q, pend_rst_q;
  logic            load_q, miss_q, clr_q;
  logic            busy_w, at_cmd, mis_now;
  logic [7:0]      ref_byte;
  cmd_info_t       info;

  pwg_cmd_decode u_dec (.code(byte_in), .info(info));

  pwg_pw_store #(.PW_BYTES(PW_BYTES), .NUM_PW(5)) u_store (
    .clk(clk), .rst(rst), .sel(sel_q), .idx(idx_q), .byte_o(ref_byte));

  pwg_busy_timer #(.BUSY_CYC(BUSY_CYC)) u_busy (
    .clk(clk), .rst(rst), .load(load_q), .busy(busy_w));

  pwg_tamper #(.TAMPER_MAX(TAMPER_MAX)) u_tamp (
    .clk(clk), .rst(rst), .miss(miss_q), .clr(clr_q), .tamper(tamper_bit));

  assign at_cmd  = (st_q == ST_CMD);
  assign mis_now = mis_q | (byte_in != ref_byte);
  assign locked  = tamper_bit;
  assign devid   = {tamper_bit, ID_CODE};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      sel_q      <= PW_MRD;
      idx_q      <= '0;
      mis_q      <= 1'b0;
      pend_ok_q  <= 1'b0;
      pend_rst_q <= 1'b0;
      load_q     <= 1'b0;
      miss_q     <= 1'b0;
      clr_q      <= 1'b0;
      ack_vld    <= 1'b0;
      ack_out    <= 1'b0;
      grant      <= 1'b0;
    end else begin
      ack_vld <= 1'b0;
      load_q  <= 1'b0;
      miss_q  <= 1'b0;
      clr_q   <= 1'b0;
      if (stop_evt) begin
        st_q  <= ST_IDLE;
        grant <= 1'b0;
      end else if (start_evt) begin
        st_q <= ST_CMD;
      end else if (byte_vld) begin
        case (st_q)
          ST_CMD: begin
            ack_vld <= 1'b1;
            ack_out <= 1'b0;
            st_q    <= ST_SKIP;
            if (busy_w) begin
              ack_out <= 1'b0;
            end else if (info.is_poll) begin
              if (pend_ok_q) begin
                ack_out <= 1'b1;
                if (pend_rst_q) begin
                  clr_q <= 1'b1;
                end else begin
                  grant <= 1'b1;
                  st_q  <= ST_DATA;
                end
              end
              pend_ok_q <= 1'b0;
            end else if (info.is_pw) begin
              if (!locked || info.is_rst) begin
                ack_out    <= 1'b1;
                sel_q      <= info.sel;
                pend_ok_q  <= 1'b0;
                pend_rst_q <= info.is_rst;
                idx_q      <= '0;
                mis_q      <= 1'b0;
                st_q       <= ST_PW;
              end
            end else if (info.is_nopw) begin
              ack_out <= 1'b1;
              st_q    <= ST_DATA;
            end
          end
          ST_PW: begin
            ack_vld <= 1'b1;
            ack_out <= 1'b1;
            mis_q   <= mis_now;
            if (idx_q == LAST_IDX) begin
              pend_ok_q <= ~mis_now;
              miss_q    <= mis_now;
              load_q    <= 1'b1;
              st_q      <= ST_SKIP;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
          ST_DATA: begin
            ack_vld <= 1'b1;
            ack_out <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwgate_chk.sv
module pwgate_chk (
  input logic       clk,
  input logic       rst,
  input logic       byte_vld,
  input logic [7:0] byte_in,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       ack_vld,
  input logic       ack_out,
  input logic       grant,
  input logic       tamper_bit,
  input logic       at_cmd,
  input logic       busy_w,
  input logic       clr_q
);
  logic plain_byte;
  assign plain_byte = byte_vld && !start_evt && !stop_evt;

  // R12
  ack_follows_byte_chk: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(byte_vld));

  // R11
  stop_drops_grant_chk: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !grant);

  // R3
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_byte && at_cmd && busy_w) |=> (ack_vld && !ack_out));

  // R4
  grant_needs_poll_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(grant) |-> ($past(byte_vld) && $past(byte_in) == 8'hF0));

  // R6
  locked_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (plain_byte && at_cmd && tamper_bit &&
     (byte_in == 8'h80 || byte_in == 8'h90 || byte_in == 8'h88 || byte_in == 8'h98))
    |=> (ack_vld && !ack_out));

  // R7
  tamper_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(tamper_bit) |-> $past(clr_q));
endmodule

bind pwgate_top pwgate_chk u_chk (
  .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
  .start_evt(start_evt), .stop_evt(stop_evt), .ack_vld(ack_vld),
  .ack_out(ack_out), .grant(grant), .tamper_bit(tamper_bit),
  .at_cmd(at_cmd), .busy_w(busy_w), .clr_q(clr_q));

// File: tb/sim_pwgate_top.sv
module sim_pwgate_top;
  localparam int          BUSY = 20;
  localparam logic [30:0] ID   = 31'h0A5C_3E1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        start_evt = 1'b0;
  logic        stop_evt = 1'b0;
  logic        ack_vld, ack_out, grant, locked, tamper_bit;
  logic [31:0] devid;

  int errors = 0;
  int checks = 0;
  int miss_cnt = 0;
  logic got_vld, got_ack;

  always #10 clk = ~clk;

  pwgate_top #(.BUSY_CYC(BUSY), .ID_CODE(ID)) u0 (
    .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
    .start_evt(start_evt), .stop_evt(stop_evt), .ack_vld(ack_vld),
    .ack_out(ack_out), .grant(grant), .locked(locked),
    .tamper_bit(tamper_bit), .devid(devid));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1'b1;
    @(negedge clk) start_evt = 1'b0;
  endtask

  task automatic do_stop();
    @(negedge clk) stop_evt = 1'b1;
    @(negedge clk) stop_evt = 1'b0;
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_in = b; byte_vld = 1'b1; end
    @(negedge clk) byte_vld = 1'b0;
    got_vld = ack_vld;
    got_ack = ack_out;
  endtask

  task automatic wait_busy();
    repeat (BUSY + 4) @(negedge clk);
  endtask

  // bad < 0: all-zero password; otherwise byte 'bad' is made nonzero
  task automatic entry(input logic [7:0] cmd, input int bad, input logic exp_cmd_ack);
    logic all_ack;
    do_start();
    send(cmd);
    check("R2 command answer", {got_vld, got_ack}, {1'b1, exp_cmd_ack});
    if (exp_cmd_ack) begin
      all_ack = 1'b1;
      for (int k = 0; k < 8; k++) begin
        send((k == bad) ? 8'(1 << k) : 8'h00);
        all_ack &= got_vld & got_ack;
      end
      check("R2 password bytes acked", all_ack, 1'b1);
      if (bad >= 0) miss_cnt++;
    end
  endtask

  task automatic poll(input logic exp_ack, input string req);
    do_start();
    send(8'hF0);
    check(req, {got_vld, got_ack}, {1'b1, exp_ack});
  endtask

  initial begin
    logic [7:0] cmds [5];
    cmds[0] = 8'h80; cmds[1] = 8'h90; cmds[2] = 8'h88; cmds[3] = 8'h98; cmds[4] = 8'hE8;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 grant", grant, 0);
    check("R1 locked", locked, 0);
    check("R1 tamper", tamper_bit, 0);
    check("R1 ack_vld", ack_vld, 0);
    check("R8 devid", devid, {1'b0, ID});

    // R9 illegal code, then standby
    do_start();
    send(8'h55);
    check("R9 illegal nack", {got_vld, got_ack}, 2'b10);
    send(8'h80);
    check("R9 standby ignores byte", got_vld, 0);
    do_stop();

    // R3 busy window, R4 poll, R11 stop
    entry(8'h80, -1, 1'b1);
    poll(1'b0, "R3 poll while busy");
    do_start();
    send(8'h90);
    check("R3 command while busy", {got_vld, got_ack}, 2'b10);
    wait_busy();
    poll(1'b1, "R4 poll after match");
    check("R4 grant raised", grant, 1);
    send(8'h12);
    check("R12 data byte answered", {got_vld, got_ack}, 2'b11);
    do_stop();
    check("R11 stop clears grant", grant, 0);
    poll(1'b0, "R4 result consumed");
    do_stop();

    // R2 every protected command with the correct password
    for (int c = 0; c < 5; c++) begin
      entry(cmds[c], -1, 1'b1);
      wait_busy();
      poll(1'b1, "R2 correct password per command");
      check("R4 grant only for non-reset", grant, (c != 4));
      do_stop();
    end

    // R10 abort by start and by stop
    do_start();
    send(8'h90);
    send(8'h00); send(8'h00); send(8'h00);
    do_start();
    send(8'h80);
    check("R10 start abort, no busy", {got_vld, got_ack}, 2'b11);
    send(8'h00);
    do_stop();
    do_start();
    send(8'h88);
    check("R10 stop abort, no busy", {got_vld, got_ack}, 2'b11);
    do_stop();

    // R5 mismatch sweep over byte positions 0..6
    for (int k = 0; k < 7; k++) begin
      entry(cmds[k % 5], k, 1'b1);
      wait_busy();
      poll(1'b0, "R5 mismatch poll nack");
      do_stop();
      check("R5 tamper below limit", tamper_bit, (miss_cnt >= 8));
    end
    entry(8'h98, -1, 1'b1);
    wait_busy();
    poll(1'b1, "R5 correct entry between misses");
    do_stop();
    entry(8'h90, 7, 1'b1);
    wait_busy();
    poll(1'b0, "R5 eighth mismatch nack");
    do_stop();
    check("R5 tamper at eighth miss", tamper_bit, (miss_cnt >= 8));
    check("R8 locked follows tamper", locked, 1);
    check("R8 devid tamper bit", devid, {1'b1, ID});

    // R6 lockout
    for (int c = 0; c < 4; c++) begin
      entry(cmds[c], -1, 1'b0);
      send(8'h00);
      check("R6 ignored after nack", got_vld, 0);
      do_stop();
    end
    do_start();
    send(8'hC8);
    check("R6 no-password read open", {got_vld, got_ack}, 2'b11);
    do_stop();
    do_start();
    send(8'hD8);
    check("R6 no-password write open", {got_vld, got_ack}, 2'b11);
    do_stop();

    // R7 reset-device clears tamper
    entry(8'hE8, -1, 1'b1);
    wait_busy();
    poll(1'b1, "R7 reset poll ack");
    @(negedge clk);
    @(negedge clk);
    check("R7 tamper cleared", tamper_bit, 0);
    check("R7 grant stays low", grant, 0);
    check("R8 devid after clear", devid, {1'b0, ID});
    do_stop();
    miss_cnt = 0;
    entry(8'h80, 3, 1'b1);
    wait_busy();
    check("R7 counter cleared", tamper_bit, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule